// File: doc/BRIEF.md
# Keyed Countdown Watchdog Timer

This block is a hardware watchdog. It runs on the fast system clock. A fixed power-of-two prescaler divides that clock down to a slow step rate, and an 8-bit counter counts down at that rate.

Software drives the watchdog with one control word. The word holds three fields:

- a start/stop command;
- a reload count;
- a 7-bit key.

A control write takes effect only when its key is the bitwise inverse of the key of the last write that took effect. A runaway program that keeps writing the same word therefore cannot keep the watchdog alive. A start both loads the count and sets the counter running, so a first start, a restart and a periodic kick are all the same operation.

Expiry comes in two stages:

1. When the counter steps down to 1, the block raises a non-maskable interrupt request. The processor gets one step period (about 1.3 ms at the default 2^17 division of a 100 MHz clock) to record its state.
2. When the counter steps down to 0, the block emits a chip reset pulse of fixed length.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the counter reads 0, the watchdog is stopped, `nmi_req` and `chip_rst` are low, and the stored key is 0x00, so the first write that can take effect carries key 0x7F.
- R2: A write (`wr_en` high at a rising clock edge) takes effect only when `wr_key` equals the stored key XOR 0x7F. When it takes effect, `wr_key` becomes the stored key.
- R3: A write whose key fails the R2 test has no effect at all: the count, the run state, the stored key and `nmi_req` are all unchanged.
- R4: An accepted write with `wr_cmd` = 1 (start) loads `wr_count` into the counter on that edge, clears the prescaler and sets the watchdog running.
- R5: While running, the counter steps down by one every 2^PRESC_W clock cycles. The first step lands exactly 2^PRESC_W edges after the start edge.
- R6: An accepted write with `wr_cmd` = 0 (stop) halts the watchdog. The count is then held until the next accepted start.
- R7: The step that takes the counter from 2 to 1 sets `nmi_req`. The request stays high through later steps, including expiry.
- R8: A step taken while the counter holds 1 or 0 leaves it at 0, stops the watchdog, and drives `chip_rst` high for exactly RST_CYCLES cycles, starting on that edge.
- R9: Any accepted write, start or stop, clears `nmi_req` on its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe, sampled at the rising edge |
| wr_cmd | input | 1 | Command field: 1 = start/kick, 0 = stop |
| wr_count | input | CNT_W (8) | Reload value for a start |
| wr_key | input | 7 | Key field of the control write |
| count_o | output | CNT_W (8) | Present counter value |
| nmi_req | output | 1 | Non-maskable interrupt request (level) |
| chip_rst | output | 1 | Chip reset pulse |

## Verification
The bench targets the following corner cases:

- **Key alternation.** Repeating the previous accepted key must be rejected. A design that compares against a fixed key, or that stores rejected keys, would let a stuck writer kick forever, or would lock out the next correct key.
- **Prescaler phase on restart.** A kick landing mid-period must restart the full 2^PRESC_W wait. A design that kept the old phase would step early.
- **Two-stage expiry.** The interrupt must come exactly one step before the reset pulse. The pulse must have the exact length, and the counter must then sit at 0.
- **Stop freezing the count.** After a stop, the count must not move.

Long random runs with correct and wrong keys mixed are compared cycle by cycle against a bench model. These runs catch ordering slips, for example a tick and a write landing on the same edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int KEY_W = 7;
  localparam logic [KEY_W-1:0] KEY_FLIP = 7'h7F;

  typedef enum logic {
    CMD_STOP  = 1'b0,
    CMD_START = 1'b1
  } wdt_cmd_e;

  // key that the next write must carry, given the stored one
  function automatic logic [KEY_W-1:0] wanted_key(input logic [KEY_W-1:0] stored);
    return stored ^ KEY_FLIP;
  endfunction

  // one countdown step, saturating at zero
  function automatic logic [7:0] step_down(input logic [7:0] v);
    return (v == 8'd0) ? 8'd0 : v - 8'd1;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int W = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  output logic tick
);
  localparam logic [W-1:0] LAST = '1;

  logic [W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clear)  div_q <= '0;
    else if (enable) div_q <= div_q + 1'b1;
  end

  assign tick = enable && !clear && (div_q == LAST);

  // a tick leaves the divider at zero for the next period
  p_tick_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (div_q == '0));

  // a clear restarts the period from zero
  p_clear_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (div_q == '0));

endmodule

// File: rtl/wdt_key_gate.sv
module wdt_key_gate
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  output logic             accept,
  output logic [KEY_W-1:0] key_q
);
  always_comb accept = wr_en && (wr_key == wanted_key(key_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (accept) key_q <= wr_key;
  end

  // rejected writes and idle cycles keep the stored key
  p_key_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(key_q));

  // each accepted write flips every key bit
  p_key_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (key_q == ($past(key_q) ^ 7'h7F)));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             halt,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             ev_warn,
  output logic             ev_expire
);
  logic step;

  always_comb begin
    step      = tick && run_q && !load && !halt;
    ev_warn   = step && (cnt_q == CNT_W'(2));
    ev_expire = step && (cnt_q <= CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (halt) begin
      run_q <= 1'b0;
    end else if (step) begin
      if (ev_expire) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= CNT_W'(step_down(8'(cnt_q)));
      end
    end
  end

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (run_q && cnt_q == $past(load_val)));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !load) |=> (!run_q && $stable(cnt_q)));

  p_expire_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> (!run_q && cnt_q == '0));

endmodule

// File: rtl/wdt_expiry_out.sv
module wdt_expiry_out #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_nmi,
  input  logic ev_warn,
  input  logic ev_expire,
  output logic nmi_q,
  output logic rst_pulse
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       nmi_q <= 1'b0;
    else if (clr_nmi) nmi_q <= 1'b0;
    else if (ev_warn) nmi_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (ev_expire)      left_q <= RW'(RST_CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign rst_pulse = (left_q != '0);

  p_nmi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q && !clr_nmi) |=> nmi_q);

  p_nmi_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_nmi |=> !nmi_q);

  p_rst_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> rst_pulse);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int PRESC_W    = 17,
  parameter int CNT_W      = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cmd,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [6:0]       wr_key,
  output logic [CNT_W-1:0] count_o,
  output logic             nmi_req,
  output logic             chip_rst
);
  logic             accept;
  logic [KEY_W-1:0] key_q;
  logic             do_start;
  logic             do_stop;
  logic             tick;
  logic             running;
  logic             ev_warn;
  logic             ev_expire;

  wdt_key_gate u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_key (wr_key),
    .accept (accept),
    .key_q  (key_q)
  );

  assign do_start = accept && (wdt_cmd_e'(wr_cmd) == CMD_START);
  assign do_stop  = accept && (wdt_cmd_e'(wr_cmd) == CMD_STOP);

  wdt_prescaler #(.W(PRESC_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .enable (running),
    .tick   (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (do_start),
    .load_val  (wr_count),
    .halt      (do_stop),
    .tick      (tick),
    .cnt_q     (count_o),
    .run_q     (running),
    .ev_warn   (ev_warn),
    .ev_expire (ev_expire)
  );

  wdt_expiry_out #(.RST_CYCLES(RST_CYCLES)) u_exp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_nmi   (accept),
    .ev_warn   (ev_warn),
    .ev_expire (ev_expire),
    .nmi_q     (nmi_req),
    .rst_pulse (chip_rst)
  );

  // the interrupt only ever appears with one step left
  p_nmi_at_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> (count_o == CNT_W'(1)));

  // the reset pulse only ever starts with the counter empty
  p_rst_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst) |-> (count_o == '0 && !running));

  // a stopped watchdog with no accepted write keeps its count
  p_stopped_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !accept) |=> $stable(count_o));

  // a rejected write leaves the key and the count untouched
  p_reject_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept && !running) |=> ($stable(key_q) && $stable(count_o)));

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 4;
  localparam int RSTN = 5;
  localparam int PER  = 1 << PW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_cmd = 1'b0;
  logic [7:0] wr_count = '0;
  logic [6:0] wr_key = '0;
  logic [7:0] count_o;
  logic       nmi_req;
  logic       chip_rst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog #(.PRESC_W(PW), .CNT_W(8), .RST_CYCLES(RSTN)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
    .wr_count(wr_count), .wr_key(wr_key),
    .count_o(count_o), .nmi_req(nmi_req), .chip_rst(chip_rst)
  );

  // ---------------- bench reference model ----------------
  logic [6:0]    m_key;
  logic          m_run;
  logic [7:0]    m_cnt;
  logic [PW-1:0] m_pre;
  logic          m_nmi;
  int            m_left;

  function automatic bit key_good(input logic [6:0] k, input logic [6:0] st);
    return (k ^ st) == 7'h7F;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_key <= '0; m_run <= 1'b0; m_cnt <= '0; m_pre <= '0;
      m_nmi <= 1'b0; m_left <= 0;
    end else begin
      if (m_left > 0) m_left <= m_left - 1;
      if (wr_en && key_good(wr_key, m_key)) begin
        m_key <= wr_key;
        m_nmi <= 1'b0;
        m_pre <= '0;
        if (wr_cmd) begin m_cnt <= wr_count; m_run <= 1'b1; end
        else m_run <= 1'b0;
      end else if (m_run) begin
        if (int'(m_pre) == PER - 1) begin
          m_pre <= '0;
          if (m_cnt <= 8'd1) begin
            m_cnt <= '0; m_run <= 1'b0; m_left <= RSTN;
          end else begin
            m_cnt <= m_cnt - 8'd1;
            if (m_cnt == 8'd2) m_nmi <= 1'b1;
          end
        end else begin
          m_pre <= m_pre + 1'b1;
        end
      end
    end
  end

  // cycle-by-cycle comparison against the model (R4 R5 R7 R8 R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (count_o !== m_cnt || nmi_req !== m_nmi || chip_rst !== (m_left > 0)) begin
        errors++;
        $display("FAIL model R5/R7/R8: cnt=%0d nmi=%0b rst=%0b expected cnt=%0d nmi=%0b rst=%0b",
                 count_o, nmi_req, chip_rst, m_cnt, m_nmi, m_left > 0);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive one write; returns at the first negedge after the write edge
  task automatic do_wr(input bit cmd, input logic [7:0] c, input logic [6:0] k);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = cmd; wr_count = c; wr_key = k;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1: reset state
    chk("R1 count", count_o, 0);
    chk("R1 nmi", nmi_req, 0);
    chk("R1 chip_rst", chip_rst, 0);

    // R3: wrong key (0x00 while 0x7F is required) ignored
    do_wr(1'b1, 8'd5, 7'h00);
    chk("R3 bad key count", count_o, 0);
    wait_n(PER + 2);
    chk("R3 still stopped", count_o, 0);

    // R2 R4: first valid key 0x7F starts count 3
    do_wr(1'b1, 8'd3, 7'h7F);
    chk("R4 load", count_o, 3);
    wait_n(PER - 1);
    chk("R5 before step", count_o, 3);
    wait_n(1);
    chk("R5 first step", count_o, 2);
    chk("R7 no nmi at 2", nmi_req, 0);
    wait_n(PER);
    chk("R7 count 1", count_o, 1);
    chk("R7 nmi set", nmi_req, 1);

    // R9 R2: kick with inverse key clears nmi and reloads
    do_wr(1'b1, 8'd4, 7'h00);
    chk("R9 nmi cleared", nmi_req, 0);
    chk("R4 reload", count_o, 4);
    // R3: repeating the same key is rejected (mid-period, phase kept)
    do_wr(1'b1, 8'd9, 7'h00);
    chk("R3 repeat key", count_o, 4);
    wait_n(PER - 2);
    chk("R5 step after kick", count_o, 3);

    // R6: stop with key 0x7F halts
    do_wr(1'b0, 8'd0, 7'h7F);
    chk("R6 stop hold", count_o, 3);
    wait_n(3 * PER);
    chk("R6 frozen", count_o, 3);
    chk("R6 no reset", chip_rst, 0);

    // R8: start count 2, run to expiry
    do_wr(1'b1, 8'd2, 7'h00);
    wait_n(PER);
    chk("R7 nmi", nmi_req, 1);
    wait_n(PER - 1);
    chk("R8 no reset yet", chip_rst, 0);
    wait_n(1);
    chk("R8 count 0", count_o, 0);
    chk("R8 reset high", chip_rst, 1);
    chk("R7 nmi held at expiry", nmi_req, 1);
    wait_n(RSTN - 1);
    chk("R8 reset last cycle", chip_rst, 1);
    wait_n(1);
    chk("R8 reset ended", chip_rst, 0);
    wait_n(2 * PER);
    chk("R8 stays stopped", count_o, 0);

    // R8 corner: start with count 1 expires at first step
    do_wr(1'b1, 8'd1, 7'h7F);
    chk("R9 nmi cleared by start", nmi_req, 0);
    wait_n(PER);
    chk("R8 count1 expiry", chip_rst, 1);
    wait_n(RSTN + 2);

    // random phase, mixed good and bad keys, checked against model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 11) == 0) begin
        wr_en    = 1'b1;
        wr_cmd   = ($urandom_range(0, 3) != 0);
        wr_count = 8'($urandom_range(0, 5));
        if ($urandom_range(0, 1) == 0) wr_key = m_key ^ 7'h7F;
        else wr_key = (m_key ^ 7'h7F) ^ 7'($urandom_range(1, 127));
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    wait_n(4);
    finish_run();
  end

endmodule